// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two operands over many clock cycles using one operand-wide adder and a double-width accumulation register. A request is issued by raising `start_i` while the block is idle. The block then captures the operands and the signedness mode. It clears the upper half of its accumulation register and places the multiplier magnitude in the lower half. On each iteration it examines the register's least significant bit. When that bit is one, it adds the multiplicand magnitude into the upper half. It then shifts the whole register, with the adder carry on top, one place to the right.

In signed mode both operands are read as two's complement. The block multiplies their magnitudes and negates the double-width result in a final cycle if exactly one operand was negative. The result stays on `product_o` until the next completion, and `done_o` marks the cycle in which a new result appears.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: With `signed_i` = 0, `product_o` equals the full unsigned 2*WIDTH-bit product of the two operands, including the all-ones by all-ones case where the adder carry reaches the top bit.
- R3: A start accepted at a clock edge raises `busy_o` after that edge. `busy_o` then stays high for exactly WIDTH+1 cycles and falls in the same cycle that `done_o` rises.
- R4: `done_o` is high for exactly one cycle per accepted request.
- R5: `start_i` raised while `busy_o` is high is ignored. The result and the completion time of the running request are unchanged.
- R6: With `signed_i` = 1, the operands are two's complement and `product_o` is the two's complement 2*WIDTH-bit product; for example, -6 times 3 gives -18.
- R7: In signed mode the most negative operand value is handled correctly, both alone and multiplied by itself.
- R8: `product_o` changes only in the cycle in which `done_o` is high and otherwise holds its last value.
- R9: Operands and mode are sampled only in the accepting cycle. Changing them while busy has no effect on the result.
- R10: A start raised in the same cycle that `done_o` is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a multiplication; taken only when idle |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2*WIDTH | Registered product |

## Verification
The hardest condition to create from the ports is a `start_i` that arrives mid-computation with different operands and a different mode. To reach it, the stimulus raises start again several cycles into a run and scrambles all operand inputs after acceptance. A cycle-level reference model then confirms that neither the result nor the completion cycle moved. A second hard case is a new request issued in the done cycle itself, which exercises the boundary between two back-to-back runs. The carry into the top bit is forced with all-ones operands.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } smul_state_t;
endpackage

// File: rtl/smul_sign.sv
// Converts an operand to magnitude form; reports whether it was negative.
module smul_sign #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             signed_i,
  output logic [WIDTH-1:0] mag_o,
  output logic             neg_o
);
  always_comb begin
    neg_o = signed_i & val_i[WIDTH-1];
    mag_o = neg_o ? (~val_i + WIDTH'(1)) : val_i;
  end
endmodule

// File: rtl/smul_ctrl.sv
// Sequencer: idle -> WIDTH add/shift iterations -> sign fix-up cycle.
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  smul_state_t state_q;
  logic [CW-1:0] iter_q;
  logic last_iter;

  assign last_iter = (iter_q == CW'(WIDTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          iter_q <= '0;
          if (start_i) state_q <= ST_RUN;
        end
        ST_RUN: begin
          iter_q <= iter_q + CW'(1);
          if (last_iter) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    load_o   = (state_q == ST_IDLE) && start_i;
    step_o   = (state_q == ST_RUN);
    finish_o = (state_q == ST_FIX);
    busy_o   = (state_q != ST_IDLE);
  end
endmodule

// File: rtl/smul_dp.sv
// Accumulation register and single WIDTH-bit adder.
module smul_dp #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] acc_o
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    acc_q;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sum_w;

  always_comb begin
    addend = acc_q[0] ? mcand_q : '0;
    sum_w  = {1'b0, acc_q[PW-1:WIDTH]} + {1'b0, addend};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load_i) begin
      acc_q   <= {{WIDTH{1'b0}}, mplier_i};
      mcand_q <= mcand_i;
    end else if (step_i) begin
      // carry enters the top bit, everything else moves one place down
      acc_q <= {sum_w, acc_q[WIDTH-1:1]};
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               signed_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int PW = 2 * WIDTH;

  logic load, step, finish;
  logic [WIDTH-1:0] mcand_mag, mplier_mag;
  logic mcand_neg, mplier_neg;
  logic neg_q, done_q;
  logic [PW-1:0] acc, prod_q;

  smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .load_o(load), .step_o(step), .finish_o(finish), .busy_o(busy_o)
  );

  smul_sign #(.WIDTH(WIDTH)) u_sign_a (
    .val_i(mcand_i), .signed_i(signed_i), .mag_o(mcand_mag), .neg_o(mcand_neg)
  );

  smul_sign #(.WIDTH(WIDTH)) u_sign_b (
    .val_i(mplier_i), .signed_i(signed_i), .mag_o(mplier_mag), .neg_o(mplier_neg)
  );

  smul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step),
    .mcand_i(mcand_mag), .mplier_i(mplier_mag), .acc_o(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q  <= 1'b0;
      done_q <= 1'b0;
      prod_q <= '0;
    end else begin
      done_q <= finish;
      if (load) neg_q <= mcand_neg ^ mplier_neg;
      if (finish) prod_q <= neg_q ? (~acc + PW'(1)) : acc;
    end
  end

  assign done_o    = done_q;
  assign product_o = prod_q;
endmodule

// File: rtl/smul_checker.sv
module smul_checker #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o
);
  localparam int LAT = WIDTH + 1;
  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else busy_cnt <= 0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R3
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o); // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_cnt == LAT); // R3
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i)); // R5
  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(product_o)); // R8
endmodule

bind shift_add_mult smul_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
);

// File: tb/shift_add_mult_bench.sv
module shift_add_mult_bench;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic signed_i = 1'b0;
  logic [W-1:0] mcand_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic busy_o, done_o;
  logic [2*W-1:0] product_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;
  string cur_tag = "R2";

  // reference model state
  bit m_busy = 0;
  bit m_done = 0;
  int m_cnt = 0;
  logic [2*W-1:0] m_prod = '0;
  logic [2*W-1:0] m_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_add_mult #(.WIDTH(W)) u_shift_add_mult (
    .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
  );

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, logic s);
    logic [2*W-1:0] ea, eb;
    ea = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  task automatic check(string tag, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_cnt <= 0; m_prod <= '0;
    end else begin
      m_done <= 0;
      if (!m_busy && start_i) begin
        m_busy <= 1;
        m_cnt  <= W + 1;
        m_pend <= ref_mul(mcand_i, mplier_i, signed_i);
      end else if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy <= 0; m_done <= 1; m_prod <= m_pend;
        end
        m_cnt <= m_cnt - 1;
      end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R3", {63'b0, busy_o}, {63'b0, m_busy});
      check("R4", {63'b0, done_o}, {63'b0, m_done});
      check(cur_tag, product_o, m_prod);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic issue(string tag, logic [W-1:0] a, logic [W-1:0] b, logic s);
    wait_idle();
    cur_tag = tag;
    mcand_i = a; mplier_i = b; signed_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R9: scramble inputs once captured
    mcand_i = ~a; mplier_i = b ^ 32'h5A5A_A5A5; signed_i = ~s;
  endtask

  task automatic run(string tag, logic [W-1:0] a, logic [W-1:0] b, logic s);
    logic [2*W-1:0] exp;
    exp = ref_mul(a, b, s);
    issue(tag, a, b, s);
    while (!done_o) @(negedge clk);
    check(tag, product_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {62'b0, busy_o, done_o}, 64'd0);
    check("R1", product_o, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {62'b0, busy_o, done_o}, 64'd0);
    check("R1", product_o, 64'd0);

    run("R2", 32'd2, 32'd3, 1'b0);
    run("R2", 32'd0, 32'hDEAD_BEEF, 1'b0);
    run("R2", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run("R2", 32'h8000_0000, 32'd2, 1'b0);
    run("R2", 32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
    run("R6", 32'hFFFF_FFFA, 32'd3, 1'b1);
    run("R6", 32'hFFFF_FFFA, 32'hFFFF_FFFB, 1'b1);
    run("R6", 32'd7, 32'hFFFF_FFFF, 1'b1);
    run("R7", 32'h8000_0000, 32'h8000_0000, 1'b1);
    run("R7", 32'h8000_0000, 32'd1, 1'b1);
    run("R7", 32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
    run("R9", 32'hCAFE_F00D, 32'h0BAD_CAFE, 1'b1);

    // R5: start with other operands mid-run is ignored
    issue("R5", 32'd1000, 32'd1000, 1'b0);
    repeat (5) @(negedge clk);
    mcand_i = 32'd7; mplier_i = 32'd9; signed_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    check("R5", product_o, 64'd1000000);
    @(negedge clk);
    check("R5", {63'b0, busy_o}, 64'd0);

    // R10: new request in the done cycle
    issue("R10", 32'd11, 32'd13, 1'b0);
    while (!done_o) @(negedge clk);
    check("R10", product_o, 64'd143);
    cur_tag = "R10";
    mcand_i = 32'd20; mplier_i = 32'd30; signed_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R10", {63'b0, busy_o}, 64'd1);
    while (!done_o) @(negedge clk);
    check("R10", product_o, 64'd600);

    // R8: value held after completion
    cur_tag = "R8";
    repeat (10) @(negedge clk);
    check("R8", product_o, 64'd600);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule